// File: doc/BRIEF.md
# Cascaded Serial DAC Update Controller

This block drives a chain of serial 12-bit voltage DACs that share one serial clock line and one active-low load line. Only the data line passes from device to device: each DAC's shift output feeds the next DAC's data input. The host presents one parallel word that holds a code for every device, together with a one-cycle start strobe. The controller then sends the whole chain as a single long word and finishes with one load pulse, so every output in the chain changes at the same moment.

The serial clock is made by dividing the system clock. The divider is worked out from the system frequency and from the highest serial rate the DACs accept, and it gives equal high and low times. Data changes only while the serial clock is low, because the DACs sample on its rising edge. The code for the device farthest from the controller goes out first. After the last rising edge, a guard interval passes before the load line is pulled low. The load line then stays low for a set number of serial periods.

A busy flag covers the whole transfer, and a single-cycle done pulse marks its end. A start strobe that arrives while busy is high is ignored.

Top module: `dac_chain_writer`

## Requirements
- R1: After reset, `sclk` is 0, `load_n` is 1, `sdata` is 0, `busy` is 0 and `done` is 0.
- R2: While a word is being shifted, every high phase and every low phase of `sclk` lasts exactly H system cycles, where H is the smallest integer with 2·H·SCLK_MAX_HZ ≥ SYS_HZ. This keeps the serial rate at or below SCLK_MAX_HZ.
- R3: `sdata` never changes in a cycle where `sclk` is high, nor in the cycle where `sclk` rises.
- R4: Each transfer gives exactly N_DEV·CODE_W rising edges on `sclk`. The bits of `codes` go out from the top bit down, so bit field `codes[k*CODE_W +: CODE_W]` ends up in device k, where device 0 is the one wired directly to `sdata`. The farthest device's code is sent first, and each code is sent MSB first.
- R5: `load_n` stays high while bits are being shifted. It falls exactly (2·GUARD_PER+1)·H system cycles after the last rising edge of `sclk`.
- R6: `load_n` goes low exactly once per transfer and stays low for exactly 2·LOAD_PER·H system cycles.
- R7: `done` is a one-cycle pulse in the cycle where `load_n` returns high. `busy` is 1 from the cycle after an accepted start through the cycle before `done`, and it is 0 while `done` is high.
- R8: A start strobe while `busy` is 1 has no effect: the transfer in progress is neither restarted nor lengthened, and its codes are unchanged. The value on `codes` is captured only when a start is accepted.
- R9: A start strobe in the same cycle as `done` is accepted, and `busy` is 1 in the following cycle.
- R10: Whenever `busy` is 0, `sclk` is low and `load_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send `codes` down the chain |
| codes | input | N_DEV*CODE_W | Device k's code in bits [k*CODE_W +: CODE_W]; device 0 is nearest |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when the load pulse ends |
| sclk | output | 1 | Shared serial clock, idles low |
| sdata | output | 1 | Serial data into the nearest DAC |
| load_n | output | 1 | Shared active-low load strobe |

## Verification
Two events can fall in the same cycle: the end of one transfer (the `done` pulse, with `load_n` rising) and the arrival of the next start strobe. The bench raises `start` in exactly the cycle where it sees `done`. It then requires `busy` in the next cycle and checks that the chained transfer is delivered complete and with correct timing. A second case places a start strobe, with different codes, in the middle of the shifting. That case is judged at the ports: the number of edges, the load pulse and the values the model DACs latch must all be those of the original request.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GUARD = 2'd2,
    ST_LOAD  = 2'd3
  } dcw_state_e;

  // System cycles per serial half period: the ceiling of sys/(2*max), at least 1.
  function automatic int half_div_calc(input int sys_hz, input int max_hz);
    int q;
    q = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
    return (q < 1) ? 1 : q;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Counter width able to hold the value n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dcw_half_tick.sv
module dcw_half_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  generate
    if (HALF_DIV == 1) begin : g_direct
      assign tick = en;
    end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;
      logic          wrap;

      assign wrap = (cnt == CW'(HALF_DIV - 1));
      assign tick = en && wrap;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (!en || wrap) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/dcw_frame_shift.sv
module dcw_frame_shift #(
  parameter int TB = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [TB-1:0] load_val,
  input  logic          shift_en,
  output logic          msb
);

  logic [TB-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (load_en) begin
      sr <= load_val;
    end else if (shift_en) begin
      sr <= {sr[TB-2:0], 1'b0};
    end
  end

  assign msb = sr[TB-1];

endmodule

// File: rtl/dcw_sequencer.sv
module dcw_sequencer
  import dcw_pkg::*;
#(
  parameter int TB           = 36,
  parameter int GUARD_HALVES = 2,
  parameter int LOAD_HALVES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done,
  output logic sclk,
  output logic load_n,
  output logic frame_load,
  output logic frame_shift
);

  localparam int BCW = cnt_width(TB);
  localparam int HCW = cnt_width(max_of(GUARD_HALVES, LOAD_HALVES));

  dcw_state_e     state;
  logic [BCW-1:0] bit_cnt;
  logic [HCW-1:0] half_cnt;
  logic           sclk_r;
  logic           load_n_r;
  logic           done_r;

  logic accept;
  logic rise_evt;
  logic fall_evt;
  logic last_bit;
  logic guard_end;
  logic load_end;

  assign accept    = (state == ST_IDLE) && start;
  assign rise_evt  = (state == ST_SHIFT) && tick && !sclk_r;
  assign fall_evt  = (state == ST_SHIFT) && tick && sclk_r;
  assign last_bit  = (bit_cnt == BCW'(TB - 1));
  assign guard_end = (state == ST_GUARD) && tick && (half_cnt == HCW'(GUARD_HALVES - 1));
  assign load_end  = (state == ST_LOAD) && tick && (half_cnt == HCW'(LOAD_HALVES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      half_cnt <= '0;
      sclk_r   <= 1'b0;
      load_n_r <= 1'b1;
      done_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_SHIFT;
            bit_cnt <= '0;
            sclk_r  <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (rise_evt) begin
            sclk_r <= 1'b1;
          end else if (fall_evt) begin
            sclk_r <= 1'b0;
            if (last_bit) begin
              state    <= ST_GUARD;
              half_cnt <= '0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_GUARD: begin
          if (guard_end) begin
            state    <= ST_LOAD;
            load_n_r <= 1'b0;
            half_cnt <= '0;
          end else if (tick) begin
            half_cnt <= half_cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          if (load_end) begin
            state    <= ST_IDLE;
            load_n_r <= 1'b1;
            done_r   <= 1'b1;
          end else if (tick) begin
            half_cnt <= half_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign done        = done_r;
  assign sclk        = sclk_r;
  assign load_n      = load_n_r;
  assign frame_load  = accept;
  assign frame_shift = fall_evt;

endmodule

// File: rtl/dac_chain_writer.sv
module dac_chain_writer
  import dcw_pkg::*;
#(
  parameter int N_DEV       = 3,
  parameter int CODE_W      = 12,
  parameter int SYS_HZ      = 10_000_000,
  parameter int SCLK_MAX_HZ = 1_400_000,
  parameter int GUARD_PER   = 1,
  parameter int LOAD_PER    = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [N_DEV*CODE_W-1:0] codes,
  output logic                    busy,
  output logic                    done,
  output logic                    sclk,
  output logic                    sdata,
  output logic                    load_n
);

  localparam int TB           = N_DEV * CODE_W;
  localparam int HALF_DIV     = half_div_calc(SYS_HZ, SCLK_MAX_HZ);
  localparam int GUARD_HALVES = 2 * GUARD_PER;
  localparam int LOAD_HALVES  = 2 * LOAD_PER;

  // Named internal events, visible to the checker.
  logic half_tick;
  logic frame_load;
  logic frame_shift;

  dcw_half_tick #(
    .HALF_DIV(HALF_DIV)
  ) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (busy),
    .tick (half_tick)
  );

  // codes is already laid out with the farthest device in the top bits,
  // so the top bit of the frame is the first one sent.
  dcw_frame_shift #(
    .TB(TB)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (frame_load),
    .load_val(codes),
    .shift_en(frame_shift),
    .msb     (sdata)
  );

  dcw_sequencer #(
    .TB          (TB),
    .GUARD_HALVES(GUARD_HALVES),
    .LOAD_HALVES (LOAD_HALVES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tick       (half_tick),
    .busy       (busy),
    .done       (done),
    .sclk       (sclk),
    .load_n     (load_n),
    .frame_load (frame_load),
    .frame_shift(frame_shift)
  );

endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
  parameter int TB        = 36,
  parameter int HALF_DIV  = 4,
  parameter int GUARD_PER = 1,
  parameter int LOAD_PER  = 1
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sdata,
  input logic load_n,
  input logic half_tick
);

  logic        sclk_q;
  logic        load_q;
  int unsigned run_len;
  int unsigned rises;
  int unsigned since_rise;
  int unsigned low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      load_q     <= 1'b1;
      run_len    <= 0;
      rises      <= 0;
      since_rise <= 0;
      low_len    <= 0;
    end else begin
      sclk_q <= sclk;
      load_q <= load_n;
      if (!busy)                run_len <= 0;
      else if (sclk != sclk_q)  run_len <= 1;
      else                      run_len <= run_len + 1;
      if (!busy)                rises <= 0;
      else if (sclk && !sclk_q) rises <= rises + 1;
      if (sclk && !sclk_q)      since_rise <= 1;
      else                      since_rise <= since_rise + 1;
      if (load_n)               low_len <= 0;
      else                      low_len <= low_len + 1;
    end
  end

  p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (sclk != sclk_q)) |-> (run_len == HALF_DIV));

  p_tick_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> busy);

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));

  p_edge_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_n) |-> (rises == TB));

  p_load_high_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> load_n);

  p_load_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_n) |-> (since_rise == (2 * GUARD_PER + 1) * HALF_DIV));

  p_load_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !load_q) |-> (low_len == 2 * LOAD_PER * HALF_DIV));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_load_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && load_n && !load_q));

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_idle_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && load_n));

endmodule

bind dac_chain_writer dcw_checker #(
  .TB       (TB),
  .HALF_DIV (HALF_DIV),
  .GUARD_PER(GUARD_PER),
  .LOAD_PER (LOAD_PER)
) u_dcw_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .sclk     (sclk),
  .sdata    (sdata),
  .load_n   (load_n),
  .half_tick(half_tick)
);

// File: tb/dac_chain_writer_test.sv
module dac_chain_writer_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_DEV      = 3;
  localparam int CODE_W     = 12;
  localparam int SYS_HZ     = 10_000_000;
  localparam int MAX_HZ     = 1_400_000;
  localparam int GUARD_PER  = 1;
  localparam int LOAD_PER   = 1;
  localparam int TB         = N_DEV * CODE_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [TB-1:0] codes = '0;
  logic          busy, done, sclk, sdata, load_n;

  dac_chain_writer #(
    .N_DEV(N_DEV), .CODE_W(CODE_W), .SYS_HZ(SYS_HZ), .SCLK_MAX_HZ(MAX_HZ),
    .GUARD_PER(GUARD_PER), .LOAD_PER(LOAD_PER)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .codes(codes),
    .busy(busy), .done(done), .sclk(sclk), .sdata(sdata), .load_n(load_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Expected half period: step up until the serial rate no longer exceeds the limit.
  function automatic int exp_half();
    int h = 1;
    while (2 * h * MAX_HZ < SYS_HZ) h++;
    return h;
  endfunction

  function automatic int exp_guard();
    return exp_half() * (1 + 2 * GUARD_PER);
  endfunction

  function automatic int exp_low();
    return exp_half() * LOAD_PER * 2;
  endfunction

  int checks = 0;
  int fails  = 0;

  // Monitor statistics, cleared at each launch.
  int rises, per_err, data_err, shift_load_err, idle_err, done_err;
  int loads, dones, guard_meas, low_meas, run, since_rise, low_run;
  logic          p_sclk = 1'b0, p_load = 1'b1, p_sdata = 1'b0;
  logic [TB-1:0] chain_sr = '0;   // model of the cascaded DAC shift registers
  logic [TB-1:0] dev_latch = '0;  // model of their output latches

  task automatic clear_stats();
    rises = 0; per_err = 0; data_err = 0; shift_load_err = 0; done_err = 0;
    loads = 0; dones = 0; guard_meas = -1; low_meas = -1;
  endtask

  initial begin
    clear_stats();
    idle_err = 0; run = 0; since_rise = 0; low_run = 0;
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (!busy) run = 0;
      else if (sclk != p_sclk) begin
        if (run != exp_half()) per_err++;
        run = 1;
      end else run++;
      if (sclk && sdata != p_sdata) data_err++;
      if (sclk && !p_sclk) begin
        rises++;
        since_rise = 0;
        chain_sr = {chain_sr[TB-2:0], sdata};
      end else since_rise++;
      if (sclk && !load_n) shift_load_err++;
      if (!busy && (sclk || !load_n)) idle_err++;
      if (!load_n && p_load) begin loads++; guard_meas = since_rise; low_run = 1; end
      else if (!load_n) low_run++;
      if (load_n && !p_load) low_meas = low_run;
      if (!load_n) dev_latch = chain_sr;
      if (done) begin
        dones++;
        if (busy || !(load_n && !p_load)) done_err++;
      end
      p_sclk = sclk; p_load = load_n; p_sdata = sdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [TB-1:0] c, input string req);
    clear_stats();
    codes = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    codes = ~c;  // capture only at acceptance (R8)
    chk(busy == 1'b1, req, "busy after start", busy, 1);
  endtask

  task automatic finish(input logic [TB-1:0] c, input string tag);
    bit seen = 0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R7", {tag, " done seen"}, seen, 1);
    chk(busy == 1'b0, "R7", {tag, " busy low at done"}, busy, 0);
    chk(done_err == 0, "R7", {tag, " done placement"}, done_err, 0);
    chk(dones == 1, "R7", {tag, " done count"}, dones, 1);
    chk(per_err == 0, "R2", {tag, " half period errors"}, per_err, 0);
    chk(data_err == 0, "R3", {tag, " data moved with sclk high"}, data_err, 0);
    chk(rises == TB, "R4", {tag, " rising edges"}, rises, TB);
    chk(dev_latch == c, "R4", {tag, " device codes"}, longint'(dev_latch), longint'(c));
    chk(shift_load_err == 0, "R5", {tag, " load low while shifting"}, shift_load_err, 0);
    chk(guard_meas == exp_guard(), "R5", {tag, " guard cycles"}, guard_meas, exp_guard());
    chk(loads == 1, "R6", {tag, " load pulses"}, loads, 1);
    chk(low_meas == exp_low(), "R6", {tag, " load width"}, low_meas, exp_low());
  endtask

  function automatic logic [TB-1:0] rnd_frame();
    logic [63:0] w;
    w = {$urandom, $urandom};
    return w[TB-1:0];
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int unsigned seed_val;
    logic [TB-1:0] a, b;
    seed_val = $urandom(32'd7341);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(sclk == 0, "R1", "sclk", sclk, 0);
    chk(load_n == 1, "R1", "load_n", load_n, 1);
    chk(sdata == 0, "R1", "sdata", sdata, 0);
    chk(busy == 0 && done == 0, "R1", "busy/done", {busy, done}, 0);

    // Directed corner frames
    launch('0, "R7"); finish('0, "zeros");
    launch('1, "R7"); finish('1, "ones");
    a = {12'h123, 12'hABC, 12'h5A5};
    launch(a, "R7"); finish(a, "distinct");

    // R8: start with other codes while shifting is ignored
    a = {12'h800, 12'h001, 12'hF0F};
    launch(a, "R7");
    repeat (60) @(negedge clk);
    codes = rnd_frame();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish(a, "R8 mid-start");

    // R9: start issued in the done cycle
    a = rnd_frame();
    b = rnd_frame();
    launch(a, "R7");
    finish(a, "R9 first");
    launch(b, "R9");
    finish(b, "R9 second");

    // Random frames
    for (int k = 0; k < 6; k++) begin
      a = rnd_frame();
      launch(a, "R7");
      finish(a, "random");
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end

    // R10: idle lines over the whole run, and a start-free idle window
    repeat (20) @(negedge clk);
    chk(idle_err == 0, "R10", "idle line violations", idle_err, 0);
    chk(dones == 1 && rises == TB, "R8", "no activity without start", rises, TB);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule